// File: doc/BRIEF.md
# TDM Serial Audio Transmitter (Target Mode)

This block turns a set of parallel audio sample words into one serial data stream. The stream is laid out as a time-division-multiplexed frame, and the timing comes from an external bit clock and frame strobe. The block does not generate any clock of its own. It oversamples the incoming bit clock and frame strobe with the fast system clock, finds their edges, and advances a slot and bit sequencer on every launch edge. The launch edge is the bit-clock edge on which new data is presented. It is the rising edge by default and the falling edge when the polarity input is set.

A frame begins when the frame strobe goes from low to high. At that moment the block captures the sample words and the per-slot enable and valid masks. It also captures the word length, the slot count and the start delay. After a programmable delay counted in bit clocks, it sends slot 0 MSB first, then every further slot in ascending order with no gaps between them. With a delay of zero, the first bit cannot wait for a launch edge. It is therefore driven as soon as the strobe edge is seen. Slots that are disabled and bit clocks after the last slot release the line: the output enable drops and the data pin reads zero. A frame strobe that arrives before the previous frame has been fully sent sets a sticky error flag, and the new frame then starts cleanly from slot 0.

Top module: `tdm_tx_port`

## Requirements
- R1: A low-to-high change of `fsync` starts a frame, and slot 0 is sent first. Keeping `fsync` high over several bit periods does not restart the frame.
- R2: Slots 0 to N-1 are sent back to back in ascending order, each as `W` bits MSB first. `cfg_wlen` code 0 selects W=16, 1 selects W=20, 2 selects W=24 and 3 selects W=32. Slot k takes its word from bits `[k*32 +: 32]` of `tx_words`, and only the low W bits of that word are sent.
- R3: Data changes only on launch edges: rising `bclk` edges when `cfg_bclk_inv`=0, falling `bclk` edges when `cfg_bclk_inv`=1.
- R4: For a delay D = `cfg_offset` ≥ 1, `sdout_oe` stays low for the first D bit periods of the frame. The MSB of slot 0 appears in bit period D, where bit period 0 is the one in which `fsync` rose.
- R5: For D = 0, the MSB of slot 0 is driven in bit period 0, within a few system clocks of the `fsync` edge. The next bit follows on the first launch edge after that.
- R6: A slot inside the active range whose `tx_enable` bit is 0 still takes up its W bit periods, but with `sdout_oe`=0 and `sdout`=0.
- R7: A slot whose `tx_enable` bit is 1 and whose `tx_valid` bit is 0 is driven (`sdout_oe`=1) with all-zero data.
- R8: After reset, and in every bit period after the last slot until the next frame starts, `sdout_oe`=0 and `sdout`=0.
- R9: `err_short` goes high if `fsync` rises again before the last bit of the current frame has been ended by a launch edge. It stays high until reset, and the new frame is sent correctly from slot 0.
- R10: A new `fsync` edge that coincides with the launch edge ending the last bit (no idle bit clocks) is legal and does not set `err_short`.
- R11: Words, masks, word length, slot count and delay are all sampled at the `fsync` edge. Changing any of them during the frame does not affect that frame.
- R12: A `cfg_slots` value of 0, or one above NSLOT, is treated as NSLOT slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample bclk and fsync |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | External frame strobe; only its rising edge matters |
| cfg_wlen | input | 2 | Word length code (0:16, 1:20, 2:24, 3:32 bits) |
| cfg_slots | input | $clog2(NSLOT+1) | Number of slots in the frame |
| cfg_offset | input | OFS_W | Bit clocks between the frame edge and the slot 0 MSB |
| cfg_bclk_inv | input | 1 | 1 selects the falling bclk edge for launch |
| tx_words | input | NSLOT*32 | Sample words, slot k at bits [k*32 +: 32] |
| tx_valid | input | NSLOT | Per-slot valid; an invalid enabled slot sends zeros |
| tx_enable | input | NSLOT | Per-slot enable; a disabled slot releases the line |
| sdout | output | 1 | Serial data output |
| sdout_oe | output | 1 | Output enable for the data pin |
| err_short | output | 1 | Sticky flag for a frame cut short by a new frame edge |

## Verification
Every result of this block is due within the same bit period as the launch edge or frame edge that causes it. The path to the pins is the two-stage input synchronizer, one edge-detect register, the sequencer register and the output register, about five system clocks in all. The bench holds each half of the bit clock for eight system clocks. It drives `bclk` and `fsync` together on a falling system-clock edge and reads `sdout`, `sdout_oe` and `err_short` on the last falling system-clock edge before the opposite `bclk` edge, which is three cycles after the outputs settle. The expected stream for each bit period comes from the configuration the bench captured when the frame edge was driven.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
   localparam int SAMPLE_W = 32;
   localparam int BIT_W    = $clog2(SAMPLE_W);

   typedef enum logic [1:0] {
      WL_16 = 2'd0,
      WL_20 = 2'd1,
      WL_24 = 2'd2,
      WL_32 = 2'd3
   } wlen_e;

   function automatic logic [BIT_W-1:0] wlen_msb(input wlen_e w);
      case (w)
         WL_16:   return BIT_W'(15);
         WL_20:   return BIT_W'(19);
         WL_24:   return BIT_W'(23);
         default: return BIT_W'(31);
      endcase
   endfunction
endpackage

// File: rtl/tdm_tx_sync.sv
module tdm_tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic prv
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tdm_tx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
         prv   <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], din};
         prv   <= chain[STAGES-1];
      end
   end

   assign lvl = chain[STAGES-1];
endmodule

// File: rtl/tdm_tx_seq.sv
module tdm_tx_seq
   import tdm_tx_pkg::*;
#(
   parameter int NSLOT = 8,
   parameter int OFS_W = 3,
   localparam int SLOT_W = $clog2(NSLOT + 1),
   localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              launch,
   input  logic [1:0]        cfg_wlen,
   input  logic [SLOT_W-1:0] cfg_slots,
   input  logic [OFS_W-1:0]  cfg_offset,
   output logic              in_data,
   output logic [IDX_W-1:0]  slot_idx,
   output logic [BIT_W-1:0]  bit_idx,
   output logic              err_short
);
   logic              lead_q, data_q, err_q;
   logic [OFS_W-1:0]  wait_q;
   logic [IDX_W-1:0]  slot_q, last_q;
   logic [BIT_W-1:0]  bit_q, msb_q;
   logic [SLOT_W-1:0] n_eff, n_m1;
   logic [BIT_W-1:0]  new_msb;
   logic              last_bit, cut;

   always_comb begin
      n_eff    = (cfg_slots == '0 || cfg_slots > SLOT_W'(NSLOT)) ? SLOT_W'(NSLOT) : cfg_slots;
      n_m1     = n_eff - SLOT_W'(1);
      new_msb  = wlen_msb(wlen_e'(cfg_wlen));
      last_bit = data_q && (bit_q == '0) && (slot_q == last_q);
      cut      = lead_q || (data_q && !(launch && last_bit));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_q <= 1'b0;
         data_q <= 1'b0;
         err_q  <= 1'b0;
         wait_q <= '0;
         slot_q <= '0;
         last_q <= '0;
         bit_q  <= '0;
         msb_q  <= '0;
      end else if (start) begin
         err_q  <= err_q | cut;
         msb_q  <= new_msb;
         last_q <= n_m1[IDX_W-1:0];
         slot_q <= '0;
         bit_q  <= new_msb;
         wait_q <= cfg_offset;
         lead_q <= (cfg_offset != '0);
         data_q <= (cfg_offset == '0);
      end else if (launch) begin
         if (lead_q) begin
            wait_q <= wait_q - OFS_W'(1);
            if (wait_q == OFS_W'(1)) begin
               lead_q <= 1'b0;
               data_q <= 1'b1;
            end
         end else if (data_q) begin
            if (bit_q == '0) begin
               if (slot_q == last_q) begin
                  data_q <= 1'b0;
               end else begin
                  slot_q <= slot_q + IDX_W'(1);
                  bit_q  <= msb_q;
               end
            end else begin
               bit_q <= bit_q - BIT_W'(1);
            end
         end
      end
   end

   assign in_data   = data_q;
   assign slot_idx  = slot_q;
   assign bit_idx   = bit_q;
   assign err_short = err_q;

   // R9: the error flag never clears on its own
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);
   // R9: a frame edge during an unfinished frame raises the flag
   p_err_on_cut_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (lead_q || (data_q && !launch))) |=> err_q);
   // R10: a frame edge together with the final launch edge is legal
   p_b2b_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !err_q && !lead_q && !data_q) |=> !err_q);
   // R5: a zero delay puts the slot 0 MSB up at once
   p_zero_ofs_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg_offset == '0) |=> (data_q && slot_q == '0 && bit_q == msb_q));
   // R4: a non-zero delay keeps the line quiet first
   p_lead_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (start && cfg_offset != '0) |=> (!data_q && lead_q));
   // R2: bits step down one per launch edge inside a slot
   p_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !start && data_q && bit_q != '0) |=> (bit_q == $past(bit_q) - BIT_W'(1)));
   // R2: slots advance by one, restarting at the MSB
   p_slot_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !start && data_q && bit_q == '0 && slot_q != last_q)
      |=> (slot_q == $past(slot_q) + IDX_W'(1) && bit_q == msb_q));
   // R3: nothing moves between edges
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!launch && !start) |=> ($stable(slot_q) && $stable(bit_q) && $stable(data_q)));
endmodule

// File: rtl/tdm_tx_shift.sv
module tdm_tx_shift
   import tdm_tx_pkg::*;
#(
   parameter int NSLOT = 8,
   localparam int IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      cap,
   input  logic [NSLOT*SAMPLE_W-1:0] words,
   input  logic [NSLOT-1:0]          valid,
   input  logic [NSLOT-1:0]          enable,
   input  logic                      in_data,
   input  logic [IDX_W-1:0]          slot_idx,
   input  logic [BIT_W-1:0]          bit_idx,
   output logic                      sdout,
   output logic                      sdout_oe
);
   logic [SAMPLE_W-1:0] word_q [NSLOT];
   logic [NSLOT-1:0]    valid_q, en_q;

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               word_q[g]  <= '0;
               valid_q[g] <= 1'b0;
               en_q[g]    <= 1'b0;
            end else if (cap) begin
               word_q[g]  <= words[g*SAMPLE_W +: SAMPLE_W];
               valid_q[g] <= valid[g];
               en_q[g]    <= enable[g];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sdout    <= 1'b0;
         sdout_oe <= 1'b0;
      end else begin
         sdout_oe <= in_data && en_q[slot_idx];
         sdout    <= in_data && en_q[slot_idx] && valid_q[slot_idx] && word_q[slot_idx][bit_idx];
      end
   end

   // R8: outside the data phase the pin is released and low
   p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !in_data |=> (!sdout_oe && !sdout));
   // R6: a disabled slot never drives
   p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && !en_q[slot_idx]) |=> (!sdout_oe && !sdout));
   // R7: an enabled but invalid slot drives zeros
   p_invalid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && en_q[slot_idx] && !valid_q[slot_idx]) |=> (sdout_oe && !sdout));
endmodule

// File: rtl/tdm_tx_port.sv
module tdm_tx_port
   import tdm_tx_pkg::*;
#(
   parameter int NSLOT       = 8,
   parameter int OFS_W       = 3,
   parameter int SYNC_STAGES = 2,
   localparam int SLOT_W = $clog2(NSLOT + 1),
   localparam int IDX_W  = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      bclk,
   input  logic                      fsync,
   input  logic [1:0]                cfg_wlen,
   input  logic [SLOT_W-1:0]         cfg_slots,
   input  logic [OFS_W-1:0]          cfg_offset,
   input  logic                      cfg_bclk_inv,
   input  logic [NSLOT*SAMPLE_W-1:0] tx_words,
   input  logic [NSLOT-1:0]          tx_valid,
   input  logic [NSLOT-1:0]          tx_enable,
   output logic                      sdout,
   output logic                      sdout_oe,
   output logic                      err_short
);
   generate
      if (NSLOT < 1) begin : g_bad_nslot
         $error("tdm_tx_port: NSLOT must be at least 1");
      end
      if (OFS_W < 2) begin : g_bad_ofs
         $error("tdm_tx_port: OFS_W must allow a delay of 3");
      end
   endgenerate

   logic bclk_lvl, bclk_prv, fs_lvl, fs_prv;
   logic launch, start, in_data;
   logic [IDX_W-1:0] slot_idx;
   logic [BIT_W-1:0] bit_idx;

   tdm_tx_sync #(.STAGES(SYNC_STAGES)) u_bclk_sync (
      .clk(clk), .rst_n(rst_n), .din(bclk), .lvl(bclk_lvl), .prv(bclk_prv));
   tdm_tx_sync #(.STAGES(SYNC_STAGES)) u_fs_sync (
      .clk(clk), .rst_n(rst_n), .din(fsync), .lvl(fs_lvl), .prv(fs_prv));

   assign start  = fs_lvl && !fs_prv;
   assign launch = cfg_bclk_inv ? (!bclk_lvl && bclk_prv) : (bclk_lvl && !bclk_prv);

   tdm_tx_seq #(.NSLOT(NSLOT), .OFS_W(OFS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .launch(launch),
      .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots), .cfg_offset(cfg_offset),
      .in_data(in_data), .slot_idx(slot_idx), .bit_idx(bit_idx),
      .err_short(err_short));

   tdm_tx_shift #(.NSLOT(NSLOT)) u_shift (
      .clk(clk), .rst_n(rst_n), .cap(start), .words(tx_words),
      .valid(tx_valid), .enable(tx_enable), .in_data(in_data),
      .slot_idx(slot_idx), .bit_idx(bit_idx),
      .sdout(sdout), .sdout_oe(sdout_oe));

   // R1: a held-high frame strobe does not start a second frame
   p_single_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);
endmodule

// File: tb/tdm_tx_port_test.sv
module tdm_tx_port_test;
   localparam int NSLOT = 8;
   localparam int OFS_W = 3;
   localparam int HALF  = 8;
   localparam int MAXP  = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0;
   logic fsync = 1'b0;
   logic [1:0] cfg_wlen = 2'd0;
   logic [3:0] cfg_slots = 4'd1;
   logic [OFS_W-1:0] cfg_offset = '0;
   logic cfg_bclk_inv = 1'b0;
   logic [NSLOT*32-1:0] tx_words = '0;
   logic [NSLOT-1:0] tx_valid = '1;
   logic [NSLOT-1:0] tx_enable = '1;
   logic sdout, sdout_oe, err_short;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic got_d [MAXP];
   logic got_o [MAXP];
   logic [NSLOT*32-1:0] s_words;
   logic [NSLOT-1:0] s_valid, s_en;
   int s_w, s_n, s_d;

   always #2 clk = ~clk;

   tdm_tx_port #(.NSLOT(NSLOT), .OFS_W(OFS_W)) uut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync),
      .cfg_wlen(cfg_wlen), .cfg_slots(cfg_slots), .cfg_offset(cfg_offset),
      .cfg_bclk_inv(cfg_bclk_inv), .tx_words(tx_words), .tx_valid(tx_valid),
      .tx_enable(tx_enable), .sdout(sdout), .sdout_oe(sdout_oe),
      .err_short(err_short));

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int wbits(input logic [1:0] c);
      case (c)
         2'd0: return 16;
         2'd1: return 20;
         2'd2: return 24;
         default: return 32;
      endcase
   endfunction

   task automatic fill_words(input logic [31:0] seed);
      for (int i = 0; i < NSLOT; i++)
         tx_words[i*32 +: 32] = seed ^ (32'h1357_9BDF * (i + 1)) ^ {i[7:0], 24'h5A3C96};
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      fsync = 1'b0;
      bclk  = cfg_bclk_inv;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic set_pol(input logic inv);
      cfg_bclk_inv = inv;
      bclk = inv;
      repeat (2*HALF) @(negedge clk);
   endtask

   // one bit period: launch edge, read before the opposite edge
   task automatic period(input logic fs, output logic d, output logic o);
      bclk  = ~cfg_bclk_inv;
      fsync = fs;
      repeat (HALF) @(negedge clk);
      d = sdout;
      o = sdout_oe;
      bclk = cfg_bclk_inv;
      repeat (HALF) @(negedge clk);
   endtask

   task automatic expect_at(input int p, output logic d, output logic o);
      int j, sl, b;
      j = p - s_d;
      if (j < 0 || j >= s_n * s_w) begin
         d = 1'b0;
         o = 1'b0;
      end else begin
         sl = j / s_w;
         b  = s_w - 1 - (j % s_w);
         o  = s_en[sl];
         d  = s_en[sl] & s_valid[sl] & s_words[sl*32 + b];
      end
   endtask

   // run nper bit periods of one frame and compare every period
   task automatic run_frame(input int nper, input int fsw, input int chg_at,
                            input string req);
      logic d, o, ed, eo;
      int bad;
      s_words = tx_words;
      s_valid = tx_valid;
      s_en    = tx_enable;
      s_w     = wbits(cfg_wlen);
      s_n     = (cfg_slots == 0 || cfg_slots > NSLOT) ? NSLOT : int'(cfg_slots);
      s_d     = int'(cfg_offset);
      bad = -1;
      ed = 1'b0;
      eo = 1'b0;
      d = 1'b0;
      o = 1'b0;
      for (int p = 0; p < nper; p++) begin
         if (p == chg_at) begin
            tx_words  = ~tx_words;
            tx_enable = ~tx_enable;
            tx_valid  = ~tx_valid;
            cfg_wlen  = cfg_wlen + 2'd1;
            cfg_offset = cfg_offset + 3'd1;
            cfg_slots = cfg_slots + 4'd1;
         end
         period(p < fsw, got_d[p], got_o[p]);
         expect_at(p, ed, eo);
         if (bad < 0 && (got_d[p] !== ed || got_o[p] !== eo)) begin
            bad = p;
            d = got_d[p];
            o = got_o[p];
            expect_at(p, ed, eo);
         end
      end
      if (bad >= 0)
         chk(1'b0, req, $sformatf("stream {data,oe} at period %0d", bad),
             {d, o}, {ed, eo});
      else
         chk(1'b1, req, "stream", 0, 0);
   endtask

   task automatic t_reset();
      do_reset();
      chk(sdout_oe === 1'b0, "R8", "oe after reset", sdout_oe, 0);
      chk(sdout === 1'b0, "R8", "data after reset", sdout, 0);
      chk(err_short === 1'b0, "R9", "error after reset", err_short, 0);
   endtask

   task automatic t_basic();
      fill_words(32'hC0DE_1234);
      cfg_wlen = 2'd0; cfg_slots = 4'd4; cfg_offset = 3'd1;
      run_frame(1 + 4*16 + 4, 1, -1, "R1 R2 R8 slot order and idle tail");
      chk(err_short === 1'b0, "R10", "no error after clean frame", err_short, 0);
   endtask

   task automatic t_wlen();
      for (int c = 1; c < 4; c++) begin
         fill_words(32'h9E37_79B9 + c);
         cfg_wlen = c[1:0]; cfg_slots = 4'd2; cfg_offset = 3'd2;
         run_frame(2 + 2*wbits(c[1:0]) + 2, 1, -1, "R2 word length");
      end
   endtask

   task automatic t_offset0();
      fill_words(32'h0BAD_F00D);
      cfg_wlen = 2'd0; cfg_slots = 4'd3; cfg_offset = 3'd0;
      run_frame(3*16 + 2, 1, -1, "R5 zero delay stream");
      chk(got_o[0] === 1'b1 && got_d[0] === s_words[15], "R5",
          "slot0 MSB in period 0", {got_d[0], got_o[0]}, {s_words[15], 1'b1});
   endtask

   task automatic t_offset_max();
      fill_words(32'h7777_1111);
      cfg_wlen = 2'd1; cfg_slots = 4'd1; cfg_offset = 3'd7;
      run_frame(7 + 20 + 2, 1, -1, "R4 delay of seven");
      chk(got_o[6] === 1'b0 && got_o[7] === 1'b1, "R4", "oe in periods 6,7",
          {got_o[6], got_o[7]}, 2'b01);
   endtask

   task automatic t_pol();
      set_pol(1'b1);
      fill_words(32'hA5A5_3C3C);
      cfg_wlen = 2'd2; cfg_slots = 4'd2; cfg_offset = 3'd1;
      run_frame(1 + 48 + 2, 1, -1, "R3 falling-edge launch");
      set_pol(1'b0);
      run_frame(1 + 48 + 2, 1, -1, "R3 rising-edge launch");
   endtask

   task automatic t_mask();
      fill_words(32'h2468_ACE0);
      tx_enable = 8'b1011_0101;
      tx_valid  = 8'b1110_1110;
      cfg_wlen = 2'd0; cfg_slots = 4'd8; cfg_offset = 3'd1;
      run_frame(1 + 8*16 + 2, 1, -1, "R6 R7 enable and valid masks");
      chk(got_o[1 + 16] === 1'b0 && got_d[1 + 16] === 1'b0, "R6",
          "disabled slot 1 released", {got_d[17], got_o[17]}, 0);
      chk(got_o[1] === 1'b1 && got_d[1] === 1'b0, "R7",
          "invalid slot 0 sends zero", {got_d[1], got_o[1]}, 1);
      tx_enable = '1;
      tx_valid  = '1;
   endtask

   task automatic t_clamp();
      fill_words(32'h5555_AAAA);
      cfg_wlen = 2'd0; cfg_slots = 4'd0; cfg_offset = 3'd1;
      run_frame(1 + 8*16 + 2, 1, -1, "R12 slot count 0 means all");
      cfg_slots = 4'd12;
      run_frame(1 + 8*16 + 2, 1, -1, "R12 slot count above limit");
   endtask

   task automatic t_fswide();
      fill_words(32'h1F2E_3D4C);
      cfg_wlen = 2'd0; cfg_slots = 4'd2; cfg_offset = 3'd1;
      run_frame(1 + 32 + 2, 6, -1, "R1 wide frame strobe");
   endtask

   task automatic t_capture();
      fill_words(32'h0F0F_00FF);
      cfg_wlen = 2'd0; cfg_slots = 4'd3; cfg_offset = 3'd2;
      run_frame(2 + 48 + 2, 1, 10, "R11 inputs captured at frame edge");
      tx_enable = '1;
      tx_valid  = '1;
   endtask

   task automatic t_b2b();
      fill_words(32'h3141_5926);
      cfg_wlen = 2'd0; cfg_slots = 4'd2; cfg_offset = 3'd2;
      run_frame(2 + 32, 1, -1, "R10 first of back-to-back frames");
      fill_words(32'h2718_2818);
      run_frame(2 + 32 + 1, 1, -1, "R10 second of back-to-back frames");
      chk(err_short === 1'b0, "R10", "no error without idle clocks", err_short, 0);
   endtask

   task automatic t_short();
      fill_words(32'h6666_9999);
      cfg_wlen = 2'd0; cfg_slots = 4'd2; cfg_offset = 3'd2;
      run_frame(20, 1, -1, "R9 truncated frame head");
      fill_words(32'hFACE_B00C);
      run_frame(2 + 32 + 2, 1, -1, "R9 frame after truncation");
      chk(err_short === 1'b1, "R9", "error after short frame", err_short, 1);
      run_frame(2 + 32 + 2, 1, -1, "R9 later frame");
      chk(err_short === 1'b1, "R9", "error stays set", err_short, 1);
      do_reset();
      chk(err_short === 1'b0, "R9", "error cleared by reset", err_short, 0);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_wlen();
      t_offset0();
      t_offset_max();
      t_pol();
      t_mask();
      t_clamp();
      t_fswide();
      t_capture();
      t_b2b();
      t_short();
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule